// File: doc/BRIEF.md
# Divide-by-three clock generator with sync

This block turns a fast base clock into two slower clocks: a processor clock at one third of the base rate, and a peripheral clock at half the processor rate. The base clock comes from one of two inputs, an external clock or an oscillator clock, and a select input picks between them. Separately, the oscillator clock is passed straight to an output of its own, whichever source is selected.

The divide counter has no known phase at power-up. A level-sensitive sync input gives it one. While sync is sampled high, the counter is held at its start phase and both generated clocks sit high. Once sync is sampled low, division restarts on the next base-clock rising edge. Several instances that receive the same synchronous sync pulse therefore produce clocks with the same phase. An active-low asynchronous reset puts the block into the same start state as sync.

All state is clocked on the rising edge of the selected base clock. The sync input must be synchronous to that clock.

Top module: `clkDiv3Gen`

## Requirements
- R1: Outside sync and reset, cpuClk repeats a pattern of three base-clock rising edges: after the edge that ends a high phase it is low for two base periods, then high for one, so it runs at one third of the base frequency with a one-third high duty.
- R2: perClk runs at half the cpuClk frequency, high for three base periods and low for three base periods. It goes low at the first cpuClk falling edge after sync or reset is released.
- R3: perClk changes level only at base edges where cpuClk falls, except when sync or reset forces it high.
- R4: With srcSel = 1 the base clock is extClk; with srcSel = 0 the base clock is oscClk.
- R5: At every base edge where syncIn is sampled high, the counter returns to its start phase and both cpuClk and perClk are high after that edge. They stay high while syncIn remains high.
- R6: After syncIn is sampled low, cpuClk goes low at the first base edge, stays low after the second, and goes high after the third.
- R7: oscOut always equals oscClk, independent of srcSel.
- R8: After srcSel changes while the block is running, at most one irregular cpuClk period occurs. After that, the low-low-high pattern of R1 and the perClk toggling of R2 and R3 resume on the newly selected clock.
- R9: While rstN is low, cpuClk and perClk are high at once, without any clock edge. After release, the sequence matches R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| extClk | input | 1 | External base clock, used when srcSel = 1 |
| oscClk | input | 1 | Oscillator base clock, used when srcSel = 0 |
| srcSel | input | 1 | Base-clock source select (1 = external, 0 = oscillator) |
| rstN | input | 1 | Asynchronous active-low reset |
| syncIn | input | 1 | Synchronous hold/restart of the divider, active high |
| cpuClk | output | 1 | Processor clock: base / 3, one-third high |
| perClk | output | 1 | Peripheral clock: cpuClk / 2, even duty |
| oscOut | output | 1 | Direct copy of oscClk |

## Verification
The hardest case to reach is a source switch in the middle of a run. The two base clocks have unrelated periods, so the mux can produce one odd edge, and the bench must find the divider's phase again without looking inside. To get there, the bench changes srcSel just after an external-clock edge and lets a few oscillator edges pass. It then waits for cpuClk to be seen high on an oscillator edge and checks the low-low-high pattern and the perClk toggling edge by edge from that point. A second hard case is forcing the start state from an arbitrary phase. The bench does this by raising syncIn, and separately by pulling rstN low between edges, with the divider stopped at some phase of its count.

// File: rtl/clkdiv_pkg.sv
`timescale 1ns/1ps
package clkdiv_pkg;

  // Per-edge commands from the phase controller to the output registers
  typedef struct packed {
    logic holdSync;     // sync sampled high: force both clocks high
    logic clkHighNext;  // cpuClk level to load at this edge
    logic pclkToggle;   // this edge ends a high phase of cpuClk
  } divStrobe_t;

endpackage

// File: rtl/divPhaseCtrl.sv
`timescale 1ns/1ps
module divPhaseCtrl
  import clkdiv_pkg::*;
#(
  parameter int DIVIDE     = 3,
  parameter int HIGH_COUNT = 1
) (
  input  logic       baseClk,
  input  logic       rstN,
  input  logic       syncIn,
  output divStrobe_t strobes
);

  localparam int PW = (DIVIDE > 1) ? $clog2(DIVIDE) : 1;
  localparam logic [PW-1:0] LAST_PHASE = PW'(DIVIDE - 1);
  localparam logic [PW-1:0] HIGH_END   = PW'(HIGH_COUNT - 1);
  localparam logic [PW-1:0] HIGH_LIM   = PW'(HIGH_COUNT);

  logic [PW-1:0] phase;
  logic [PW-1:0] nextPhase;

  // Wrap at the last phase; any illegal code also falls back to zero
  always_comb begin
    if (phase >= LAST_PHASE) nextPhase = '0;
    else                     nextPhase = phase + PW'(1);
  end

  always_ff @(posedge baseClk or negedge rstN) begin
    if (!rstN)       phase <= '0;
    else if (syncIn) phase <= '0;
    else             phase <= nextPhase;
  end

  always_comb begin
    strobes.holdSync    = syncIn;
    strobes.clkHighNext = !syncIn && (nextPhase < HIGH_LIM);
    strobes.pclkToggle  = !syncIn && (phase == HIGH_END);
  end

  // Counter never leaves the legal range
  p_phase_legal_r1: assert property (@(posedge baseClk) disable iff (!rstN)
    phase <= LAST_PHASE);

  // Sync puts the counter back at its start phase
  p_sync_restart_r5: assert property (@(posedge baseClk) disable iff (!rstN)
    syncIn |=> (phase == '0));

endmodule

// File: rtl/divOutRegs.sv
`timescale 1ns/1ps
module divOutRegs
  import clkdiv_pkg::*;
#(
  parameter int DIVIDE     = 3,
  parameter int HIGH_COUNT = 1
) (
  input  logic       baseClk,
  input  logic       rstN,
  input  divStrobe_t strobes,
  output logic       cpuClkQ,
  output logic       pclkQ
);

  always_ff @(posedge baseClk or negedge rstN) begin
    if (!rstN) begin
      cpuClkQ <= 1'b1;
      pclkQ   <= 1'b1;
    end else if (strobes.holdSync) begin
      cpuClkQ <= 1'b1;
      pclkQ   <= 1'b1;
    end else begin
      cpuClkQ <= strobes.clkHighNext;
      if (strobes.pclkToggle) pclkQ <= ~pclkQ;
    end
  end

  // Sync forces both clocks high
  p_sync_high_r5: assert property (@(posedge baseClk) disable iff (!rstN)
    strobes.holdSync |=> (cpuClkQ && pclkQ));

  // perClk moves only with a cpuClk fall, unless sync forced it
  p_pclk_on_fall_r3: assert property (@(posedge baseClk) disable iff (!rstN)
    (!$stable(pclkQ) && !$past(strobes.holdSync)) |-> $fell(cpuClkQ));

  generate
    if (DIVIDE == 3 && HIGH_COUNT == 1) begin : g_div3_checks
      // A single high base period
      p_clk_low_after_high_r1: assert property (@(posedge baseClk)
        disable iff (!rstN || strobes.holdSync)
        cpuClkQ |=> !cpuClkQ);
      // Two low base periods, then high
      p_clk_high_after_two_low_r1: assert property (@(posedge baseClk)
        disable iff (!rstN || strobes.holdSync)
        (!cpuClkQ && $past(!cpuClkQ)) |=> cpuClkQ);
    end
  endgenerate

endmodule

// File: rtl/clkDiv3Gen.sv
`timescale 1ns/1ps
module clkDiv3Gen
  import clkdiv_pkg::*;
#(
  parameter int DIVIDE     = 3,
  parameter int HIGH_COUNT = 1
) (
  input  logic extClk,
  input  logic oscClk,
  input  logic srcSel,
  input  logic rstN,
  input  logic syncIn,
  output logic cpuClk,
  output logic perClk,
  output logic oscOut
);

  logic       baseClk;
  divStrobe_t strobes;

  // Source pick (R4); the switch itself is not glitch-protected
  assign baseClk = srcSel ? extClk : oscClk;
  // Oscillator pass-through, independent of the pick (R7)
  assign oscOut  = oscClk;

  divPhaseCtrl #(.DIVIDE(DIVIDE), .HIGH_COUNT(HIGH_COUNT)) i_ctrl (
    .baseClk (baseClk),
    .rstN    (rstN),
    .syncIn  (syncIn),
    .strobes (strobes)
  );

  divOutRegs #(.DIVIDE(DIVIDE), .HIGH_COUNT(HIGH_COUNT)) i_regs (
    .baseClk (baseClk),
    .rstN    (rstN),
    .strobes (strobes),
    .cpuClkQ (cpuClk),
    .pclkQ   (perClk)
  );

endmodule

// File: tb/test_clkDiv3Gen.sv
`timescale 1ns/1ps
module test_clkDiv3Gen;

  logic extClk = 1'b0;
  logic oscClk = 1'b0;
  logic srcSel = 1'b1;
  logic rstN   = 1'b0;
  logic syncIn = 1'b0;
  logic cpuClk, perClk, oscOut;

  int nCompared   = 0;
  int nMismatched = 0;

  clkDiv3Gen i_clkDiv3Gen (
    .extClk (extClk),
    .oscClk (oscClk),
    .srcSel (srcSel),
    .rstN   (rstN),
    .syncIn (syncIn),
    .cpuClk (cpuClk),
    .perClk (perClk),
    .oscOut (oscOut)
  );

  always #2.5 extClk = ~extClk;  // 200 MHz
  always #4   oscClk = ~oscClk;  // slower, unrelated oscillator

  task automatic check(input string req, input string what, input logic act, input logic exp);
    nCompared++;
    if (act !== exp) begin
      nMismatched++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  // One rising edge of the selected source, then settle
  task automatic step();
    if (srcSel) @(posedge extClk);
    else        @(posedge oscClk);
    #1;
  endtask

  // Edge-by-edge pattern starting from the start phase (R1, R2, R3, R6)
  task automatic runPattern(input int nEdges);
    logic expClk = 1'b1;
    logic expP   = 1'b1;
    for (int k = 1; k <= nEdges; k++) begin
      logic prevClk = expClk;
      logic prevP   = perClk;
      step();
      expClk = (k % 3 == 0);
      if (prevClk && !expClk) expP = ~expP;
      if (k <= 3) check("R6", "cpuClk after release", cpuClk, expClk);
      else        check("R1", "cpuClk pattern", cpuClk, expClk);
      check("R2", "perClk pattern", perClk, expP);
      if (perClk !== prevP) check("R3", "perClk moved on cpuClk fall", prevClk && !cpuClk, 1'b1);
    end
  endtask

  task automatic syncHold(input int nEdges);
    syncIn = 1'b1;
    for (int k = 0; k < nEdges; k++) begin
      step();
      check("R5", "cpuClk held high", cpuClk, 1'b1);
      check("R5", "perClk held high", perClk, 1'b1);
    end
    syncIn = 1'b0;
  endtask

  task automatic testReset();
    #3;
    check("R9", "cpuClk in reset", cpuClk, 1'b1);
    check("R9", "perClk in reset", perClk, 1'b1);
    step();
    rstN = 1'b1;
    runPattern(9);
  endtask

  task automatic testSyncExt();
    srcSel = 1'b1;
    step();
    syncHold(4);
    runPattern(18);
  endtask

  task automatic testSyncOsc();
    srcSel = 1'b0;
    step(); step();
    syncHold(3);
    runPattern(18);   // R4: edges counted on oscClk
  endtask

  task automatic testMidSync();
    srcSel = 1'b1;
    step(); step();   // arbitrary phase
    syncHold(1);
    runPattern(6);
    step();           // stop mid-pattern again
    syncHold(2);
    runPattern(6);
  endtask

  task automatic testSwitch();
    logic prevClk;
    logic expP;
    int   found = 0;
    srcSel = 1'b1;
    syncHold(1);
    runPattern(4);
    srcSel = 1'b0;    // R8: switch while running
    for (int k = 0; k < 6; k++) step();
    for (int k = 0; k < 4 && found == 0; k++) begin
      step();
      if (cpuClk === 1'b1) found = 1;
    end
    check("R8", "cpuClk high found after switch", found[0], 1'b1);
    prevClk = 1'b1;
    expP    = perClk;
    for (int j = 1; j <= 9; j++) begin
      logic expClk;
      step();
      expClk = (j % 3 == 0);
      if (prevClk && !expClk) expP = ~expP;
      check("R8", "cpuClk after switch", cpuClk, expClk);
      check("R8", "perClk after switch", perClk, expP);
      prevClk = expClk;
    end
  endtask

  task automatic testOscPass();
    for (int s = 0; s < 2; s++) begin
      srcSel = s[0];
      @(posedge oscClk); #1;
      check("R7", "oscOut high", oscOut, 1'b1);
      @(negedge oscClk); #1;
      check("R7", "oscOut low", oscOut, 1'b0);
    end
  endtask

  task automatic testAsyncReset();
    srcSel = 1'b1;
    syncHold(1);
    runPattern(4);    // cpuClk low here
    rstN = 1'b0;
    #0.5;
    check("R9", "cpuClk async reset", cpuClk, 1'b1);
    check("R9", "perClk async reset", perClk, 1'b1);
    step();
    rstN = 1'b1;
    runPattern(6);
  endtask

  initial begin
    #100000;
    nMismatched++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

  initial begin
    testReset();
    testSyncExt();
    testSyncOsc();
    testMidSync();
    testSwitch();
    testOscPass();
    testAsyncReset();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatched);
    $finish;
  end

endmodule